// File: doc/BRIEF.md
# Synchronous Serial Transmit Engine

This block is the transmit half of a master-side synchronous serial port. Software fills up to four byte-wide data slots through a plain register write port. The block then shifts a frame of 8, 16 or 32 bits out on a serial data line. It drives a serial clock and an active-low chip-select around each frame. The serial clock idles low. Data changes while the clock is low and is valid at each rising clock edge.

Two flags pace software. The empty flag says the slots have been copied into the shifter, so the next frame can be written. The end flag says the line has gone quiet with nothing left to send. Each flag comes with a one-cycle interrupt pulse. Bit order is selectable. The order in which the byte slots leave the block follows from that choice: with LSB-first the highest used slot goes first, and with MSB-first slot 0 goes first. The serial clock is the system clock divided by twice a programmable count.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, tdre=1, tend=1, csn=1 and sclk=0.
- R2: cfg_len selects the frame length. The value 0 gives 8 rising sclk edges per chip-select window, 1 gives 16, and 2 or 3 gives 32. The frame uses slots 0 up to 0, 1 or 3 respectively.
- R3: With cfg_lsb_first=0, slot 0 (wr_addr=0) is sent first, then the higher slots in ascending order. Each byte is sent from bit 7 down to bit 0.
- R4: With cfg_lsb_first=1, the highest used slot is sent first, then the lower slots in descending order down to slot 0. Each byte is sent from bit 0 up to bit 7.
- R5: sclk is low whenever csn is high. sdo does not change while sclk is high. The first bit is already on sdo in the cycle csn falls.
- R6: While csn is low, every low and high level of sclk lasts exactly cfg_div system cycles. This includes the level from the csn fall to the first rising edge and the level from the last falling edge to the csn rise. A cfg_div of 0 acts as 1.
- R7: Writing the highest used slot of the current length clears tdre and tend on the next cycle. Writes to lower slots leave both flags unchanged.
- R8: When the slots are copied into the shifter, csn falls, tdre is set and irq_empty pulses for exactly that one cycle.
- R9: When csn rises at the end of a frame and tdre=1, tend is set and irq_end pulses for one cycle. If new data is pending at that point (tdre=0), the next frame starts without setting tend.
- R10: Between two frames, csn stays high for at least 2*cfg_div system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data slot write strobe |
| wr_addr | input | 2 | Data slot index |
| wr_data | input | 8 | Byte to store |
| cfg_len | input | 2 | Frame length: 0=8, 1=16, 2 or 3=32 bits |
| cfg_lsb_first | input | 1 | 1 selects LSB-first order, 0 selects MSB-first |
| cfg_div | input | DIV_W | Half-period of sclk in system cycles |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| csn | output | 1 | Chip-select, active low |
| tdre | output | 1 | Data slots empty flag |
| tend | output | 1 | Transmission ended flag |
| irq_empty | output | 1 | One-cycle pulse when the slots are taken |
| irq_end | output | 1 | One-cycle pulse when transmission ends |

## Verification
The bench builds the block with its default DIV_W of 8. It changes cfg_div at run time between 1, 2 and 3. A divide of 1 exercises the shortest possible sclk levels, where each state advances on every tick. A divide of 3 shows that the level length is counted, not fixed. Every length and bit order is sent with distinct bytes, so a swapped slot or reversed bit shows up. A back-to-back pair at divide 2 reaches the path where a frame finishes with data already pending.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int BYTE_W    = 8;
  localparam int NREG      = 4;
  localparam int FRAME_MAX = BYTE_W * NREG;
  localparam int BIT_CNT_W = $clog2(FRAME_MAX);
  localparam int ADDR_W    = $clog2(NREG);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_GAP
  } st_e;

  // highest slot index used by a length code
  function automatic logic [ADDR_W-1:0] last_index(input logic [1:0] len);
    case (len)
      2'd0:    return ADDR_W'(0);
      2'd1:    return ADDR_W'(1);
      default: return ADDR_W'(NREG - 1);
    endcase
  endfunction

  function automatic byte_t flip_byte(input byte_t x);
    byte_t o;
    for (int i = 0; i < BYTE_W; i++) o[i] = x[BYTE_W-1-i];
    return o;
  endfunction

  // serial stream, first bit in the MSB position
  function automatic logic [FRAME_MAX-1:0] order_bits(input byte_t [NREG-1:0] r,
                                                      input logic [1:0] len,
                                                      input logic lsb);
    if (!lsb) return {r[0], r[1], r[2], r[3]};
    case (len)
      2'd0:    return {flip_byte(r[0]), {(3*BYTE_W){1'b0}}};
      2'd1:    return {flip_byte(r[1]), flip_byte(r[0]), {(2*BYTE_W){1'b0}}};
      default: return {flip_byte(r[3]), flip_byte(r[2]), flip_byte(r[1]), flip_byte(r[0])};
    endcase
  endfunction
endpackage

// File: rtl/sst_baud.sv
module sst_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick    = run && (cnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sst_txregs.sv
module sst_txregs import sst_pkg::*; (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  byte_t                  wr_data,
  input  logic [1:0]             len,
  output byte_t [NREG-1:0]       slots,
  output logic                   last_wr
);
  byte_t mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign slots[g] = mem[g];
  end

  assign last_wr = wr_en && (wr_addr == last_index(len));
endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl import sst_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  byte_t [NREG-1:0] slots,
  input  logic [1:0]       len,
  input  logic             lsb,
  input  logic             last_wr,
  output logic             run,
  output logic             sclk,
  output logic             sdo,
  output logic             csn,
  output logic             tdre,
  output logic             tend,
  output logic             irq_empty,
  output logic             irq_end
);
  st_e                    st;
  logic [FRAME_MAX-1:0]   sh;
  logic [FRAME_MAX-1:0]   load_vec;
  logic [BIT_CNT_W-1:0]   left;
  logic [BIT_CNT_W-1:0]   frame_m1;
  logic                   gap_half;

  assign load_vec = order_bits(slots, len, lsb);
  assign frame_m1 = BIT_CNT_W'((int'(last_index(len)) + 1) * BYTE_W - 1);
  assign run      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sh        <= '0;
      left      <= '0;
      gap_half  <= 1'b0;
      sclk      <= 1'b0;
      sdo       <= 1'b0;
      csn       <= 1'b1;
      tdre      <= 1'b1;
      tend      <= 1'b1;
      irq_empty <= 1'b0;
      irq_end   <= 1'b0;
    end else begin
      irq_empty <= 1'b0;
      irq_end   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (!tdre) begin
            sh        <= load_vec;
            sdo       <= load_vec[FRAME_MAX-1];
            left      <= frame_m1;
            csn       <= 1'b0;
            tdre      <= 1'b1;
            irq_empty <= 1'b1;
            st        <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (tick) begin
            sclk <= 1'b1;
            st   <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (left == '0) begin
              st <= ST_TAIL;
            end else begin
              sh   <= sh << 1;
              sdo  <= sh[FRAME_MAX-2];
              left <= left - BIT_CNT_W'(1);
              st   <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            csn      <= 1'b1;
            gap_half <= 1'b0;
            if (tdre) begin
              tend    <= 1'b1;
              irq_end <= 1'b1;
            end
            st <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_half) st <= ST_IDLE;
            else          gap_half <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (last_wr) begin
        tdre    <= 1'b0;
        tend    <= 1'b0;
        irq_end <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx import sst_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_lsb_first,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              sclk,
  output logic              sdo,
  output logic              csn,
  output logic              tdre,
  output logic              tend,
  output logic              irq_empty,
  output logic              irq_end
);
  byte_t [NREG-1:0] slots;
  logic             last_wr;
  logic             run;
  logic             tick;

  sst_txregs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .len     (cfg_len),
    .slots   (slots),
    .last_wr (last_wr)
  );

  sst_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (cfg_div),
    .tick (tick)
  );

  sst_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .slots     (slots),
    .len       (cfg_len),
    .lsb       (cfg_lsb_first),
    .last_wr   (last_wr),
    .run       (run),
    .sclk      (sclk),
    .sdo       (sdo),
    .csn       (csn),
    .tdre      (tdre),
    .tend      (tend),
    .irq_empty (irq_empty),
    .irq_end   (irq_end)
  );
endmodule

// File: rtl/sync_ser_tx_chk.sv
module sync_ser_tx_chk import sst_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        cfg_len,
  input logic              sclk,
  input logic              sdo,
  input logic              csn,
  input logic              tdre,
  input logic              tend,
  input logic              irq_empty,
  input logic              irq_end
);
  p_idle_clk_low_r5: assert property (@(posedge clk) disable iff (rst)
    csn |-> !sclk);

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo));

  p_clear_on_last_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == last_index(cfg_len)) |=> (!tdre && !tend));

  p_empty_at_cs_fall_r8: assert property (@(posedge clk) disable iff (rst)
    irq_empty |-> (!csn && $past(csn)));

  p_empty_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(tdre) |-> irq_empty);

  p_empty_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_empty |=> !irq_empty);

  p_end_at_cs_rise_r9: assert property (@(posedge clk) disable iff (rst)
    irq_end |-> (tend && csn && !$past(csn)));
endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (.*);

// File: tb/test_sync_ser_tx.sv
module test_sync_ser_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = '0;
  logic       cfg_lsb_first = 1'b0;
  logic [7:0] cfg_div = 8'd3;
  logic sclk, sdo, csn, tdre, tend, irq_empty, irq_end;

  always #2.5 clk = ~clk;

  sync_ser_tx i_sync_ser_tx (.*);

  int checks = 0, errors = 0;
  logic exp_q[$];
  int   len_q[$];
  int   cur_div = 3;
  int   empty_cnt = 0, end_cnt = 0;
  bit   seen_frame = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic p_sclk = 1'b0, p_csn = 1'b1;
  int   run_len = 0, edges = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_empty) empty_cnt++;
      if (irq_end)   end_cnt++;
      if (sclk && !p_sclk) begin
        edges++;
        check(!csn, "R5 clock edge outside chip-select", csn, 0);
        if (exp_q.size() == 0) check(0, "R2 unexpected sclk edge", edges, 0);
        else begin
          automatic logic e = exp_q.pop_front();
          check(sdo == e, "R3 R4 serial bit", sdo, e);
        end
      end
      if (sclk != p_sclk || csn != p_csn) begin
        if (!p_csn) check(run_len == cur_div, "R6 sclk level length", run_len, cur_div);
        if (p_csn && !csn) begin
          if (seen_frame) check(run_len >= 2*cur_div, "R10 chip-select gap", run_len, 2*cur_div);
          check(irq_empty && tdre, "R8 load pulse at csn fall", {irq_empty, tdre}, 3);
          check(sdo == exp_q[0], "R5 first bit at csn fall", sdo, exp_q[0]);
          seen_frame = 1;
          edges = 0;
        end
        if (!p_csn && csn) begin
          automatic int el = (len_q.size() > 0) ? len_q.pop_front() : -1;
          check(edges == el, "R2 edges per frame", edges, el);
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      p_sclk = sclk;
      p_csn  = csn;
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: writes one frame and pushes its expected bits
  task automatic send(input int lc, input bit lsb, input logic [7:0] b [4]);
    automatic int nb = (lc == 0) ? 1 : (lc == 1) ? 2 : 4;
    cfg_len = 2'(lc); cfg_lsb_first = lsb;
    for (int k = 0; k < nb; k++) begin
      if (lsb) for (int i = 0; i < 8; i++)  exp_q.push_back(b[nb-1-k][i]);
      else     for (int i = 7; i >= 0; i--) exp_q.push_back(b[k][i]);
    end
    len_q.push_back(nb*8);
    for (int a = 0; a < nb; a++) begin
      automatic logic pre_tdre = tdre, pre_tend = tend;
      wr(a, b[a]);
      if (a < nb-1)
        check(tdre == pre_tdre && tend == pre_tend, "R7 lower slot write keeps flags",
              {tdre, tend}, {pre_tdre, pre_tend});
      else
        check(!tdre && !tend, "R7 last slot write clears flags", {tdre, tend}, 0);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(tend && csn && exp_q.size() == 0) && n < 20000);
    repeat (2*cur_div + 3) @(negedge clk);
    check(tend == 1'b1, "R9 tend after frame", tend, 1);
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
  endtask

  initial begin
    int c = 0;
    while (!done && c < 150000) begin @(posedge clk); c++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=finish", c);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] f [4];
    int e0, x0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tdre == 1, "R1 tdre reset", tdre, 1);
    check(tend == 1, "R1 tend reset", tend, 1);
    check(csn == 1,  "R1 csn reset", csn, 1);
    check(sclk == 0, "R1 sclk reset", sclk, 0);

    cur_div = 3; cfg_div = 8'd3;
    f = '{8'hA5, 8'h00, 8'h00, 8'h00};
    e0 = end_cnt;
    send(0, 0, f); wait_idle();
    check(end_cnt == e0 + 1, "R9 one end pulse", end_cnt, e0 + 1);
    f = '{8'h3C, 8'h00, 8'h00, 8'h00}; send(0, 1, f); wait_idle();
    f = '{8'h12, 8'hC4, 8'h00, 8'h00}; send(1, 0, f); wait_idle();
    f = '{8'h12, 8'hC4, 8'h00, 8'h00}; send(1, 1, f); wait_idle();

    cur_div = 1; cfg_div = 8'd1;
    f = '{8'h81, 8'h42, 8'h2C, 8'hF0}; send(2, 0, f); wait_idle();
    f = '{8'h81, 8'h42, 8'h2C, 8'hF0}; send(3, 1, f); wait_idle();

    // back-to-back, second frame written while the first is shifting
    cur_div = 2; cfg_div = 8'd2;
    e0 = end_cnt; x0 = empty_cnt;
    f = '{8'h5A, 8'h96, 8'h00, 8'h00}; send(1, 1, f);
    while (csn) @(negedge clk);
    f = '{8'hE1, 8'h07, 8'h00, 8'h00}; send(1, 1, f);
    wait_idle();
    check(end_cnt == e0 + 1, "R9 no end between pending frames", end_cnt, e0 + 1);
    check(empty_cnt == x0 + 2, "R8 two load pulses", empty_cnt, x0 + 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule